// File: doc/BRIEF.md
# Split Multi-Mode Timer

This block is a memory-mapped timer that is set up either as one wide counter with eight operating modes or as two independent half-width counters. A shared power-of-two prescaler turns the bus clock into count ticks. The wide counter compares against a terminal count and against a compare/capture register. It drives one output pin, whose sense is set by a polarity bit, and it samples one external input pin. Software programs the block through a 32-bit register port. Word writes take effect on the next clock edge, and reads return data combinationally for the address that is presented.

Each counter that reaches its terminal count raises a sticky interrupt flag. Software clears a flag by writing a one to it. A single interrupt line reports the flags that software has enabled. When the split bit is set, bits 0 and 1 of the control word stop acting as the wide counter's mode field. Each becomes the one-bit mode of one half (0 = one-shot, 1 = continuous). Each half then counts in its own count register and compares against its own terminal-count register.

Top module: `split_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, `irq` is low and `tmr_out` is low.
- R2: Word offsets are: control 0x00, wide count 0x04, wide terminal 0x08, compare/capture 0x0C, half-0 count 0x10, half-0 terminal 0x14, half-1 count 0x18, half-1 terminal 0x1C, flags 0x20, interrupt enables 0x24. The control word holds:
  - mode in bits 2:0
  - split select in bit 3
  - prescale code in bits 7:4
  - polarity in bit 8
  - enables in bits 12 (counter 0 or the wide counter) and 13 (counter 1)

  Writes whose address has nonzero low two bits are ignored. Reads of unused or misaligned addresses return zero.
- R3: Prescale code n ticks once every 2^n clocks, and codes above 12 behave as 12. The prescaler restarts whenever both enables are clear, so the first tick comes 2^n clocks after an enable is set.
- R4: In continuous mode (1), the wide counter adds one per tick. When the count equals the terminal value on a tick, the counter sets flag bit 0, reloads to 1 and toggles the output state.
- R5: One-shot mode (0) behaves like continuous mode, and in addition clears enable bit 12 on the terminal tick, after which the count holds.
- R6: PWM mode (3) also toggles the output state on a tick where the count equals the compare register.
- R7: Counter mode (2) advances on each active edge of `tmr_in` instead of on ticks. The active edge is rising with polarity 0 and falling with polarity 1. The input passes a two-stage synchronizer.
- R8: Gated mode (6) advances on ticks only while the synchronized input is at its active level (high with polarity 0, low with polarity 1).
- R9: Capture mode (4) copies the count into the compare/capture register and sets flag bit 0 on an active input edge. Measure mode (7) does the same on either edge and also restarts the count at 1.
- R10: Compare mode (5) sets flag bit 0 and toggles the output at the terminal value, but keeps incrementing instead of reloading.
- R11: With the split bit set, each half counts ticks while its enable is set, independently of the other half. A half sets its own flag bit (half 0 = bit 0, half 1 = bit 1) and reloads to 1 at terminal count. A half in one-shot mode clears its own enable at that point.
- R12: A control write that would change the split bit while either enable is set leaves the split bit unchanged. The other fields of that write still take effect.
- R13: Writing 1 to a flag bit clears it, and a hardware set in the same cycle wins over the clear. `irq` is high when any flag is set together with its enable bit. `tmr_out` is the output state XOR the polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tmr_in | input | 1 | External timer input, asynchronous |
| tmr_out | output | 1 | Timer output pin |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a flag-clear write that lands in the same clock as a hardware set of that flag, because the write must meet a terminal tick exactly. The stimulus creates this by programming a terminal value of 1 with prescale code 0 in continuous mode. The counter then hits terminal count on every clock, so any clear write collides with a set. A behavioural reference model, compared on every clock, also covers the collision of a one-shot stop with a control write and the input edges that arrive through the synchronizer.

// File: rtl/split_timer_pkg.sv
// Shared encodings for the split timer: mode codes, register word indices
// and control-word bit positions. Assumes 32-bit word-aligned registers.
package split_timer_pkg;

    typedef enum logic [2:0] {
        MD_ONCE  = 3'd0,
        MD_CONT  = 3'd1,
        MD_EVCNT = 3'd2,
        MD_PWM   = 3'd3,
        MD_CAPT  = 3'd4,
        MD_CMP   = 3'd5,
        MD_GATE  = 3'd6,
        MD_MEAS  = 3'd7
    } tmr_mode_e;

    // Word index = byte offset / 4
    localparam int RG_CTRL   = 0;
    localparam int RG_CNT    = 1;
    localparam int RG_TERM   = 2;
    localparam int RG_CAP    = 3;
    localparam int RG_HCNT0  = 4;
    localparam int RG_HTERM0 = 5;
    localparam int RG_FLAG   = 8;
    localparam int RG_IEN    = 9;

    localparam int B_DUAL = 3;
    localparam int B_PSC  = 4;
    localparam int B_POL  = 8;
    localparam int B_EN   = 12;

endpackage

// File: rtl/tmr_prescaler.sv
// Power-of-two tick generator. Assumes code values above PSC_MAX mean
// PSC_MAX. The counter is held at zero while run is low, so the first
// tick arrives 2^code clocks after run rises.
module tmr_prescaler #(
    parameter int PSC_MAX = 12,
    parameter int CODE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int PC_W = PSC_MAX;

    logic [PC_W-1:0]   pcnt;
    logic [PC_W-1:0]   mask;
    logic [CODE_W-1:0] eff;

    // Clamp the code and form the low-bit mask that marks a tick
    always_comb begin
        eff  = (code > CODE_W'(PSC_MAX)) ? CODE_W'(PSC_MAX) : code;
        mask = (PC_W'(1) << eff) - PC_W'(1);
        tick = run && ((pcnt & mask) == mask);
    end

    // Free-running divider counter, cleared while idle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pcnt <= '0;
        else                pcnt <= pcnt + PC_W'(1);
    end
endmodule

// File: rtl/tmr_core32.sv
// Wide counter with eight modes. Assumes the input level and edge strobes
// come already synchronized, and that a software load wins over hardware
// updates of the same register. Reports flag sets and one-shot stops upward.
module tmr_core32 import split_timer_pkg::*; #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  tmr_mode_e    mode,
    input  logic         pol,
    input  logic         tick,
    input  logic         lvl,
    input  logic         redge,
    input  logic         fedge,
    input  logic [W-1:0] term,
    input  logic         ld_cnt,
    input  logic         ld_cap,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cap,
    output logic         tout,
    output logic         flag_set,
    output logic         stop_req
);
    logic aedge, alvl, adv, hit, cmp_hit, meas, capt;

    // Decide whether this cycle advances the count and which events fire
    always_comb begin
        aedge = pol ? fedge : redge;
        alvl  = lvl ^ pol;
        case (mode)
            MD_EVCNT: adv = run && aedge;
            MD_GATE:  adv = run && tick && alvl;
            default:  adv = run && tick;
        endcase
        hit      = adv && (cnt == term);
        cmp_hit  = adv && (mode == MD_PWM) && (cnt == cap);
        meas     = run && (mode == MD_MEAS) && (redge || fedge);
        capt     = run && (mode == MD_CAPT) && aedge;
        flag_set = hit || meas || capt;
        stop_req = hit && (mode == MD_ONCE);
    end

    // Count, capture and output-state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            cap  <= '0;
            tout <= 1'b0;
        end else begin
            if (ld_cnt)    cnt <= ld_val;
            else if (meas) cnt <= W'(1);
            else if (adv)  cnt <= (hit && mode != MD_CMP) ? W'(1) : cnt + W'(1);
            if (ld_cap)              cap <= ld_val;
            else if (meas || capt)   cap <= cnt;
            if (hit || cmp_hit) tout <= ~tout;
        end
    end
endmodule

// File: rtl/tmr_half16.sv
// One half-width counter used in split operation. Assumes run already
// includes the split select. cont=0 is one-shot, cont=1 continuous.
module tmr_half16 #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         cont,
    input  logic         tick,
    input  logic [W-1:0] term,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt,
    output logic         hit,
    output logic         stop
);
    // Terminal detection on an advancing tick
    always_comb begin
        hit  = run && tick && (cnt == term);
        stop = hit && !cont;
    end

    // Count register with software load priority
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (ld)            cnt <= ld_val;
        else if (run && tick)   cnt <= hit ? W'(1) : cnt + W'(1);
    end
endmodule

// File: rtl/split_timer.sv
// Register file, input synchronizer and interrupt logic of the split timer.
// Assumes a single clock for bus and prescaler input, word-aligned access,
// and CNT_W no wider than the 32-bit data bus.
module split_timer import split_timer_pkg::*; #(
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 6,
    parameter int PSC_MAX = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tmr_in,
    output logic              tmr_out,
    output logic              irq
);
    localparam int BUS_W  = 32;
    localparam int HALF_W = CNT_W / 2;
    localparam int IDX_W  = ADDR_W - 2;
    localparam int NHALF  = 2;

    logic [2:0]        mode_q;
    logic              dual_q, pol_q;
    logic [3:0]        psc_q;
    logic [NHALF-1:0]  en_q, flag_q, ien_q;
    logic [CNT_W-1:0]  term32, cnt32, cap32;
    logic [HALF_W-1:0] hterm [NHALF];
    logic [HALF_W-1:0] hcnt  [NHALF];
    logic [NHALF-1:0]  hhit, hstop, wr_hcnt, wr_hterm, set, stop;
    logic [2:0]        sync;
    logic [IDX_W-1:0]  idx;
    logic              aligned, any_en, tick, run32, set32, stop32, tout;
    logic              w_ctrl, w_cnt, w_term, w_cap, w_flag, w_ien;

    // Address decode into per-register write strobes
    always_comb begin
        idx     = bus_addr[ADDR_W-1:2];
        aligned = (bus_addr[1:0] == 2'b00);
        w_ctrl  = bus_wr && aligned && (idx == IDX_W'(RG_CTRL));
        w_cnt   = bus_wr && aligned && (idx == IDX_W'(RG_CNT));
        w_term  = bus_wr && aligned && (idx == IDX_W'(RG_TERM));
        w_cap   = bus_wr && aligned && (idx == IDX_W'(RG_CAP));
        w_flag  = bus_wr && aligned && (idx == IDX_W'(RG_FLAG));
        w_ien   = bus_wr && aligned && (idx == IDX_W'(RG_IEN));
        for (int i = 0; i < NHALF; i++) begin
            wr_hcnt[i]  = bus_wr && aligned && (idx == IDX_W'(RG_HCNT0 + 2 * i));
            wr_hterm[i] = bus_wr && aligned && (idx == IDX_W'(RG_HTERM0 + 2 * i));
        end
    end

    // Shared status: enable summary, wide-counter run, event merging
    always_comb begin
        any_en = |en_q;
        run32  = !dual_q && en_q[0];
        set    = {hhit[1], hhit[0] | set32};
        stop   = {hstop[1], hstop[0] | stop32};
    end

    tmr_prescaler #(.PSC_MAX(PSC_MAX), .CODE_W(4)) u_psc (
        .clk(clk), .rst_n(rst_n), .run(any_en), .code(psc_q), .tick(tick)
    );

    tmr_core32 #(.W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run(run32), .mode(tmr_mode_e'(mode_q)),
        .pol(pol_q), .tick(tick), .lvl(sync[1]),
        .redge(sync[1] & ~sync[2]), .fedge(~sync[1] & sync[2]),
        .term(term32), .ld_cnt(w_cnt), .ld_cap(w_cap),
        .ld_val(bus_wdata[CNT_W-1:0]), .cnt(cnt32), .cap(cap32),
        .tout(tout), .flag_set(set32), .stop_req(stop32)
    );

    for (genvar i = 0; i < NHALF; i++) begin : g_half
        tmr_half16 #(.W(HALF_W)) u_half (
            .clk(clk), .rst_n(rst_n), .run(dual_q & en_q[i]), .cont(mode_q[i]),
            .tick(tick), .term(hterm[i]), .ld(wr_hcnt[i]),
            .ld_val(bus_wdata[HALF_W-1:0]), .cnt(hcnt[i]),
            .hit(hhit[i]), .stop(hstop[i])
        );
    end

    // Control, terminal, flag, enable and synchronizer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0; dual_q <= 1'b0; psc_q <= '0; pol_q <= 1'b0;
            en_q   <= '0; flag_q <= '0;   ien_q <= '0; term32 <= '0;
            sync   <= '0;
            for (int i = 0; i < NHALF; i++) hterm[i] <= '0;
        end else begin
            en_q <= en_q & ~stop;
            if (w_ctrl) begin
                mode_q <= bus_wdata[2:0];
                psc_q  <= bus_wdata[B_PSC +: 4];
                pol_q  <= bus_wdata[B_POL];
                en_q   <= bus_wdata[B_EN +: NHALF];
                if (!any_en) dual_q <= bus_wdata[B_DUAL];
            end
            if (w_term) term32 <= bus_wdata[CNT_W-1:0];
            for (int i = 0; i < NHALF; i++)
                if (wr_hterm[i]) hterm[i] <= bus_wdata[HALF_W-1:0];
            if (w_ien) ien_q <= bus_wdata[NHALF-1:0];
            flag_q <= (flag_q & ~(w_flag ? bus_wdata[NHALF-1:0] : '0)) | set;
            sync   <= {sync[1:0], tmr_in};
        end
    end

    // Read mux and output pins
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (idx)
                IDX_W'(RG_CTRL):       bus_rdata = {18'b0, en_q, 3'b0, pol_q, psc_q, dual_q, mode_q};
                IDX_W'(RG_CNT):        bus_rdata = BUS_W'(cnt32);
                IDX_W'(RG_TERM):       bus_rdata = BUS_W'(term32);
                IDX_W'(RG_CAP):        bus_rdata = BUS_W'(cap32);
                IDX_W'(RG_HCNT0):      bus_rdata = BUS_W'(hcnt[0]);
                IDX_W'(RG_HTERM0):     bus_rdata = BUS_W'(hterm[0]);
                IDX_W'(RG_HCNT0 + 2):  bus_rdata = BUS_W'(hcnt[1]);
                IDX_W'(RG_HTERM0 + 2): bus_rdata = BUS_W'(hterm[1]);
                IDX_W'(RG_FLAG):       bus_rdata = BUS_W'(flag_q);
                IDX_W'(RG_IEN):        bus_rdata = BUS_W'(ien_q);
                default:               bus_rdata = '0;
            endcase
        end
        irq     = |(flag_q & ien_q);
        tmr_out = tout ^ pol_q;
    end
endmodule

// File: rtl/split_timer_chk.sv
// Temporal checks on the split timer, attached by bind. Assumes the
// internal names of split_timer listed in the bind below.
module split_timer_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_wr,
    input logic         irq,
    input logic         dual,
    input logic         any_en,
    input logic         en0,
    input logic [3:0]   psc,
    input logic         tick,
    input logic         oneshot_stop,
    input logic         core_run,
    input logic [W-1:0] cnt32
);
    // R3
    psc_first_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_en && !$past(any_en) && psc != 4'd0) |-> !tick);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_run && !bus_wr) |=> $stable(cnt32));

    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oneshot_stop && !bus_wr) |=> !en0);

    // R11
    split_wide_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dual && !bus_wr) |=> $stable(cnt32));

    // R12
    dual_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_en |=> $stable(dual));

    // R13
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_wr));
endmodule

bind split_timer split_timer_chk #(.W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .irq(irq), .dual(dual_q),
    .any_en(any_en), .en0(en_q[0]), .psc(psc_q), .tick(tick),
    .oneshot_stop(stop32), .core_run(run32), .cnt32(cnt32)
);

// File: tb/split_timer_bench.sv
module split_timer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tmr_in = 1'b0;
    logic        tmr_out, irq;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    split_timer u_split_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_in(tmr_in),
        .tmr_out(tmr_out), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [2:0]  m_mode;
    logic        m_dual, m_pol, m_tout;
    logic [3:0]  m_psc;
    logic [1:0]  m_en, m_flag, m_ien;
    logic [31:0] m_cnt, m_term, m_cap;
    logic [15:0] m_hc [2];
    logic [15:0] m_ht [2];
    int          m_pcnt;
    logic        m_s1, m_s2, m_s3;

    task automatic model_step();
        bit any, tk, re, fe, ae, al, run, adv, hit, cmp, meas, capt, h;
        int n, idx;
        logic [1:0]  set, stop, nen, nflag;
        logic [31:0] ncnt, ncap;
        logic [15:0] nhc [2];
        if (!rst_n) begin
            m_mode = 0; m_dual = 0; m_pol = 0; m_tout = 0; m_psc = 0;
            m_en = 0; m_flag = 0; m_ien = 0; m_cnt = 0; m_term = 0; m_cap = 0;
            m_pcnt = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
            for (int i = 0; i < 2; i++) begin m_hc[i] = 0; m_ht[i] = 0; end
            return;
        end
        any  = (m_en != 0);
        n    = (m_psc > 12) ? 12 : int'(m_psc);
        tk   = any && ((m_pcnt % (1 << n)) == (1 << n) - 1);
        re   = m_s2 && !m_s3;
        fe   = !m_s2 && m_s3;
        ae   = m_pol ? fe : re;
        al   = m_pol ? !m_s2 : m_s2;
        run  = !m_dual && m_en[0];
        adv  = run && ((m_mode == 2) ? ae : (m_mode == 6) ? (tk && al) : tk);
        hit  = adv && (m_cnt == m_term);
        cmp  = adv && (m_mode == 3) && (m_cnt == m_cap);
        meas = run && (m_mode == 7) && (re || fe);
        capt = run && (m_mode == 4) && ae;
        ncnt = meas ? 32'd1 : adv ? ((hit && m_mode != 5) ? 32'd1 : m_cnt + 1) : m_cnt;
        ncap = (meas || capt) ? m_cnt : m_cap;
        if (hit || cmp) m_tout = ~m_tout;
        set  = {1'b0, hit || meas || capt};
        stop = {1'b0, hit && (m_mode == 0)};
        for (int i = 0; i < 2; i++) begin
            nhc[i] = m_hc[i];
            if (m_dual && m_en[i] && tk) begin
                h = (m_hc[i] == m_ht[i]);
                nhc[i] = h ? 16'd1 : m_hc[i] + 1;
                if (h) set[i] = 1'b1;
                if (h && !m_mode[i]) stop[i] = 1'b1;
            end
        end
        nen   = m_en & ~stop;
        nflag = m_flag | set;
        m_pcnt = any ? (m_pcnt + 1) % 4096 : 0;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = tmr_in;
        idx = int'(bus_addr[5:2]);
        if (bus_wr && bus_addr[1:0] == 2'b00) begin
            case (idx)
                0: begin
                    m_mode = bus_wdata[2:0]; m_psc = bus_wdata[7:4];
                    m_pol = bus_wdata[8]; nen = bus_wdata[13:12];
                    if (!any) m_dual = bus_wdata[3];
                end
                1: ncnt = bus_wdata;
                2: m_term = bus_wdata;
                3: ncap = bus_wdata;
                4: nhc[0] = bus_wdata[15:0];
                5: m_ht[0] = bus_wdata[15:0];
                6: nhc[1] = bus_wdata[15:0];
                7: m_ht[1] = bus_wdata[15:0];
                8: nflag = (m_flag & ~bus_wdata[1:0]) | set;
                9: m_ien = bus_wdata[1:0];
                default: ;
            endcase
        end
        m_en = nen; m_flag = nflag; m_cnt = ncnt; m_cap = ncap;
        m_hc[0] = nhc[0]; m_hc[1] = nhc[1];
    endtask

    function automatic logic [31:0] model_rd(logic [5:0] a);
        if (a[1:0] != 2'b00) return 32'd0;
        case (int'(a[5:2]))
            0: return {18'd0, m_en, 3'd0, m_pol, m_psc, m_dual, m_mode};
            1: return m_cnt;
            2: return m_term;
            3: return m_cap;
            4: return {16'd0, m_hc[0]};
            5: return {16'd0, m_ht[0]};
            6: return {16'd0, m_hc[1]};
            7: return {16'd0, m_ht[1]};
            8: return {30'd0, m_flag};
            9: return {30'd0, m_ien};
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) model_step();

    // ---------------- checking helpers ----------------
    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock; compare the outputs against the model away from the edge
    task automatic step();
        @(negedge clk);
        chk(cur_req, bus_rdata, model_rd(bus_addr));
        chk(cur_req, {31'd0, irq}, {31'd0, |(m_flag & m_ien)});
        chk(cur_req, {31'd0, tmr_out}, {31'd0, m_tout ^ m_pol});
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(string req, logic [5:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic wave(int n, int half_period);
        for (int k = 0; k < n; k++) begin
            if (k % half_period == 0) tmr_in = ~tmr_in;
            step();
        end
    endtask

    function automatic logic [31:0] cw(int md, int dual, int psc, int pol, int en);
        return 32'(md) | (32'(dual) << 3) | (32'(psc) << 4) | (32'(pol) << 8) | (32'(en) << 12);
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        cur_req = "R1";
        for (int a = 0; a < 10; a++) rd("R1", 6'(a * 4), 32'd0);
        chk("R1", {31'd0, irq}, 32'd0);
        chk("R1", {31'd0, tmr_out}, 32'd0);

        // R2: register map, control layout, misaligned writes
        cur_req = "R2";
        wr(6'h08, 32'h1234_5678);
        wr(6'h24, 32'h3);
        wr(6'h00, cw(5, 0, 15, 1, 0));
        wr(6'h0A, 32'h0);
        rd("R2", 6'h08, 32'h1234_5678);
        rd("R2", 6'h24, 32'h3);
        rd("R2", 6'h00, 32'h0000_01F5);
        rd("R2", 6'h0A, 32'h0);
        wr(6'h00, 32'h0);

        // R3: prescaler, first tick after 2^n clocks
        cur_req = "R3";
        wr(6'h08, 32'd100);
        wr(6'h04, 32'd0);
        wr(6'h00, cw(1, 0, 2, 0, 1));
        bus_addr = 6'h04;
        idle(8);
        rd("R3", 6'h04, 32'd2);
        wr(6'h00, 32'h0);
        wr(6'h04, 32'd0);
        wr(6'h08, 32'd1);
        wr(6'h00, cw(1, 0, 14, 0, 1));
        bus_addr = 6'h04;
        idle(9000);
        wr(6'h00, 32'h0);

        // R4: continuous wrap, flag, toggle
        cur_req = "R4";
        wr(6'h20, 32'h3);
        wr(6'h04, 32'd0);
        wr(6'h08, 32'd3);
        wr(6'h00, cw(1, 0, 1, 0, 1));
        bus_addr = 6'h04;
        idle(40);
        rd("R4", 6'h20, 32'h1);
        wr(6'h00, 32'h0);

        // R13: irq, W1C, set beats clear
        cur_req = "R13";
        chk("R13", {31'd0, irq}, 32'd1);
        wr(6'h20, 32'h1);
        rd("R13", 6'h20, 32'h0);
        chk("R13", {31'd0, irq}, 32'd0);
        wr(6'h04, 32'd1);
        wr(6'h08, 32'd1);
        wr(6'h00, cw(1, 0, 0, 0, 1));
        idle(3);
        wr(6'h20, 32'h1);
        rd("R13", 6'h20, 32'h1);
        wr(6'h00, 32'h0);
        wr(6'h20, 32'h3);

        // R5: one-shot
        cur_req = "R5";
        wr(6'h04, 32'd0);
        wr(6'h08, 32'd4);
        wr(6'h00, cw(0, 0, 0, 0, 1));
        bus_addr = 6'h04;
        idle(20);
        rd("R5", 6'h00, 32'h0);
        rd("R5", 6'h04, 32'd1);
        wr(6'h20, 32'h3);

        // R6: PWM with inverted output
        cur_req = "R6";
        wr(6'h04, 32'd0);
        wr(6'h0C, 32'd2);
        wr(6'h08, 32'd5);
        wr(6'h00, cw(3, 0, 0, 1, 1));
        bus_addr = 6'h04;
        idle(40);
        wr(6'h00, 32'h0);

        // R7: counting input edges, both polarities
        cur_req = "R7";
        wr(6'h04, 32'd0);
        wr(6'h08, 32'd4);
        wr(6'h00, cw(2, 0, 3, 0, 1));
        bus_addr = 6'h04;
        wave(60, 3);
        wr(6'h00, cw(2, 0, 3, 1, 1));
        bus_addr = 6'h04;
        wave(60, 4);
        wr(6'h00, 32'h0);

        // R8: gated by input level
        cur_req = "R8";
        wr(6'h04, 32'd0);
        wr(6'h08, 32'd50);
        wr(6'h00, cw(6, 0, 0, 0, 1));
        bus_addr = 6'h04;
        wave(70, 7);
        wr(6'h00, cw(6, 0, 0, 1, 1));
        bus_addr = 6'h04;
        wave(70, 5);
        wr(6'h00, 32'h0);

        // R9: capture then measure
        cur_req = "R9";
        wr(6'h20, 32'h3);
        wr(6'h04, 32'd0);
        wr(6'h08, 32'd200);
        wr(6'h00, cw(4, 0, 0, 0, 1));
        bus_addr = 6'h0C;
        wave(60, 9);
        wr(6'h00, cw(7, 0, 0, 0, 1));
        bus_addr = 6'h0C;
        wave(60, 6);
        wr(6'h00, 32'h0);

        // R10: compare keeps counting past terminal
        cur_req = "R10";
        wr(6'h04, 32'd0);
        wr(6'h08, 32'd3);
        wr(6'h00, cw(5, 0, 0, 0, 1));
        bus_addr = 6'h04;
        idle(12);
        rd("R10", 6'h04, 32'd12);
        wr(6'h00, 32'h0);
        wr(6'h20, 32'h3);

        // R11: split operation
        cur_req = "R11";
        wr(6'h00, cw(0, 1, 0, 0, 0));
        wr(6'h14, 32'd3);
        wr(6'h1C, 32'd5);
        wr(6'h10, 32'd0);
        wr(6'h18, 32'd0);
        wr(6'h00, cw(1, 1, 1, 0, 3));
        bus_addr = 6'h10;
        idle(20);
        bus_addr = 6'h18;
        idle(20);
        rd("R11", 6'h18, 32'd1);
        rd("R11", 6'h20, 32'h3);

        // R12: split select locked while enabled
        cur_req = "R12";
        wr(6'h00, cw(1, 0, 1, 0, 1));
        rd("R12", 6'h00, cw(1, 1, 1, 0, 1));
        wr(6'h00, cw(1, 1, 1, 0, 0));
        wr(6'h00, cw(1, 0, 1, 0, 0));
        rd("R12", 6'h00, cw(1, 0, 1, 0, 0));
        idle(4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule